// File: doc/BRIEF.md
# Dual-Rate Timer Time Base

This block is the time base for a timer. It makes a fine tick by dividing the system clock by a linear factor from 1 to 64. It then makes a coarse "loop" tick by dividing the fine tick again by a power of two from 1 to 32. Both ticks are one-cycle enables, not derived clocks. The fine tick drives two functions: a PWM generator whose edges fall on fine-tick boundaries, and a pulse-width capture that counts fine ticks while the input pin is high.

Software writes three registers through a single write port. Register 0 holds both prescale codes. Register 1 holds the PWM period and register 2 holds the PWM high time, both counted in fine ticks. A prescale write is held pending and takes effect only at the next loop tick, so no fine or coarse tick is ever cut short. The loop tick is brought out on a pin so that other timer logic can run on the coarse period.

Top module: `tdr_timebase`

## Requirements
- R1: Register 0 bits [5:0] hold the fine code c. The fine divide factor is c+1, so a fine period lasts c+1 clocks (code 63 gives 64).
- R2: Register 0 bits [8:6] hold the coarse code k. For k from 0 to 5 the divide factor is 2^k, and `loop_tick` pulses once every (c+1)·2^k clocks.
- R3: Coarse codes 6 and 7 behave as a divide factor of 32.
- R4: A write to register 0 leaves the current loop period unchanged. The new codes take effect at the next `loop_tick`, and both counters restart there.
- R5: With period P in register 1 and high time D in register 2 (0 < D < P), `pwm_out` is high for D fine periods and low for P−D fine periods. With D=1 and fine code 0, the high time is one clock.
- R6: D=0 holds `pwm_out` low. D ≥ P holds `pwm_out` high. New period and duty values load at the wrap of the PWM count.
- R7: A falling edge of `pulse_in` gives a one-clock `cap_valid` pulse. With it, `cap_width` reports the number of fine ticks that occurred while the input was high. With fine code 0 this equals the number of high clocks.
- R8: The capture count saturates at 2^CAP_W−1 (1023 by default) and does not wrap.
- R9: After reset both codes are 0, so `loop_tick` pulses every clock, and `pwm_out` and `cap_valid` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 prescale, 1 period, 2 duty |
| cfg_wdata | input | 9 | Write data |
| pulse_in | input | 1 | Input whose high time is measured |
| pwm_out | output | 1 | PWM output |
| loop_tick | output | 1 | One-clock pulse per coarse period |
| cap_valid | output | 1 | One-clock pulse when a width is reported |
| cap_width | output | 10 | Last captured width in fine ticks |

## Verification
The assertions assume the following about the inputs:
- `pulse_in` is already synchronous to `clk`. The block samples it through a single flop and does no metastability filtering.
- Writes go only to addresses 0 to 2.
- The PWM count bound is checked only when the active period is nonzero.

The bench keeps its stimulus within these limits. It drives every input at the falling clock edge and writes only the three defined registers. Before it measures timing, it waits out the deferred reload of the prescale codes and of the PWM settings.

// File: rtl/tdr_pkg.sv
`timescale 1ns/1ps
package tdr_pkg;

  typedef enum logic [1:0] {
    REG_PRESC  = 2'd0,
    REG_PERIOD = 2'd1,
    REG_DUTY   = 2'd2,
    REG_NONE   = 2'd3
  } tdr_reg_e;

  // Terminal count of the coarse stage: 2^code - 1, codes above max_log clamp.
  function automatic int unsigned coarse_last(input int unsigned code,
                                              input int unsigned max_log);
    int unsigned lg;
    lg = (code > max_log) ? max_log : code;
    return (32'd1 << lg) - 32'd1;
  endfunction

endpackage

// File: rtl/tdr_rst_sync.sv
`timescale 1ns/1ps
module tdr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/tdr_prescaler.sv
`timescale 1ns/1ps
module tdr_prescaler
  import tdr_pkg::*;
#(
  parameter int FINE_W         = 6,
  parameter int COARSE_CODE_W  = 3,
  parameter int COARSE_MAX_LOG = 5
) (
  input  logic                     clk,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [FINE_W-1:0]        fine_code_i,
  input  logic [COARSE_CODE_W-1:0] crs_code_i,
  output logic                     fine_tick_o,
  output logic                     loop_tick_o
);
  localparam int CrsW = (COARSE_MAX_LOG > 0) ? COARSE_MAX_LOG : 1;

  logic [FINE_W-1:0]        pend_fine_q, pend_fine_d, fine_code_q, fine_code_d;
  logic [COARSE_CODE_W-1:0] pend_crs_q, pend_crs_d, crs_code_q, crs_code_d;
  logic [FINE_W-1:0]        fine_cnt_q, fine_cnt_d;
  logic [CrsW-1:0]          crs_cnt_q, crs_cnt_d, crs_last;
  logic                     fine_tick, loop_tick;

  always_comb begin
    crs_last  = CrsW'(coarse_last(32'(crs_code_q), COARSE_MAX_LOG));
    fine_tick = (fine_cnt_q == fine_code_q);
    loop_tick = fine_tick && (crs_cnt_q == crs_last);

    pend_fine_d = we_i ? fine_code_i : pend_fine_q;
    pend_crs_d  = we_i ? crs_code_i  : pend_crs_q;
    fine_code_d = fine_code_q;
    crs_code_d  = crs_code_q;

    if (loop_tick) begin
      fine_cnt_d  = '0;
      crs_cnt_d   = '0;
      fine_code_d = pend_fine_q;
      crs_code_d  = pend_crs_q;
    end else if (fine_tick) begin
      fine_cnt_d = '0;
      crs_cnt_d  = crs_cnt_q + CrsW'(1);
    end else begin
      fine_cnt_d = fine_cnt_q + FINE_W'(1);
      crs_cnt_d  = crs_cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_fine_q <= '0;
      pend_crs_q  <= '0;
      fine_code_q <= '0;
      crs_code_q  <= '0;
      fine_cnt_q  <= '0;
      crs_cnt_q   <= '0;
    end else begin
      pend_fine_q <= pend_fine_d;
      pend_crs_q  <= pend_crs_d;
      fine_code_q <= fine_code_d;
      crs_code_q  <= crs_code_d;
      fine_cnt_q  <= fine_cnt_d;
      crs_cnt_q   <= crs_cnt_d;
    end
  end

  assign fine_tick_o = fine_tick;
  assign loop_tick_o = loop_tick;

  // R1: the fine counter never runs past the active terminal count
  a_r1_fine_bound: assert property (@(posedge clk) disable iff (!rst_ni)
    fine_cnt_q <= fine_code_q);
  // R2: the coarse counter never runs past the active terminal count
  a_r2_coarse_bound: assert property (@(posedge clk) disable iff (!rst_ni)
    crs_cnt_q <= crs_last);
  // R4: active codes only change right after a loop tick
  a_r4_reload_on_loop: assert property (@(posedge clk) disable iff (!rst_ni)
    ((fine_code_q != $past(fine_code_q)) || (crs_code_q != $past(crs_code_q)))
      |-> $past(loop_tick));
endmodule

// File: rtl/tdr_pwm.sv
`timescale 1ns/1ps
module tdr_pwm #(
  parameter int PWM_W = 8
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             fine_tick_i,
  input  logic             per_we_i,
  input  logic             duty_we_i,
  input  logic [PWM_W-1:0] wdata_i,
  output logic             pwm_o
);
  logic [PWM_W-1:0] per_pend_q, per_pend_d, duty_pend_q, duty_pend_d;
  logic [PWM_W-1:0] per_act_q, per_act_d, duty_act_q, duty_act_d;
  logic [PWM_W-1:0] cnt_q, cnt_d;
  logic [PWM_W:0]   cnt_inc;
  logic             wrap, pwm_q, pwm_d;

  always_comb begin
    per_pend_d  = per_we_i  ? wdata_i : per_pend_q;
    duty_pend_d = duty_we_i ? wdata_i : duty_pend_q;
    cnt_inc     = {1'b0, cnt_q} + {{PWM_W{1'b0}}, 1'b1};
    wrap        = (cnt_inc >= {1'b0, per_act_q});
    per_act_d   = per_act_q;
    duty_act_d  = duty_act_q;
    cnt_d       = cnt_q;
    if (fine_tick_i) begin
      if (wrap) begin
        cnt_d      = '0;
        per_act_d  = per_pend_q;
        duty_act_d = duty_pend_q;
      end else begin
        cnt_d = cnt_inc[PWM_W-1:0];
      end
    end
    pwm_d = (cnt_q < duty_act_q);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      per_pend_q  <= '0;
      duty_pend_q <= '0;
      per_act_q   <= '0;
      duty_act_q  <= '0;
      cnt_q       <= '0;
      pwm_q       <= 1'b0;
    end else begin
      per_pend_q  <= per_pend_d;
      duty_pend_q <= duty_pend_d;
      per_act_q   <= per_act_d;
      duty_act_q  <= duty_act_d;
      cnt_q       <= cnt_d;
      pwm_q       <= pwm_d;
    end
  end

  assign pwm_o = pwm_q;

  // R5: the count stays inside the active period
  a_r5_cnt_in_period: assert property (@(posedge clk) disable iff (!rst_ni)
    (per_act_q != '0) |-> (cnt_q < per_act_q));
  // R6: zero duty keeps the output low
  a_r6_zero_duty_low: assert property (@(posedge clk) disable iff (!rst_ni)
    (duty_act_q == '0) |=> !pwm_o);
  // R6: duty at or above the period keeps the output high
  a_r6_full_duty_high: assert property (@(posedge clk) disable iff (!rst_ni)
    ((per_act_q != '0) && (duty_act_q >= per_act_q)) |=> pwm_o);
endmodule

// File: rtl/tdr_capture.sv
`timescale 1ns/1ps
module tdr_capture #(
  parameter int CAP_W = 10
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             fine_tick_i,
  input  logic             pin_i,
  output logic             valid_o,
  output logic [CAP_W-1:0] width_o
);
  localparam logic [CAP_W-1:0] CntMax = '1;

  logic             pin_s_q, pin_d_q, fall;
  logic [CAP_W-1:0] cnt_q, cnt_d, width_q, width_d;
  logic             valid_q, valid_d;

  always_comb begin
    fall = pin_d_q && !pin_s_q;
    if (fall)                                                cnt_d = '0;
    else if (pin_s_q && fine_tick_i && (cnt_q != CntMax))    cnt_d = cnt_q + CAP_W'(1);
    else                                                     cnt_d = cnt_q;
    valid_d = fall;
    width_d = fall ? cnt_q : width_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_s_q <= 1'b0;
      pin_d_q <= 1'b0;
      cnt_q   <= '0;
      valid_q <= 1'b0;
      width_q <= '0;
    end else begin
      pin_s_q <= pin_i;
      pin_d_q <= pin_s_q;
      cnt_q   <= cnt_d;
      valid_q <= valid_d;
      width_q <= width_d;
    end
  end

  assign valid_o = valid_q;
  assign width_o = width_q;

  // R7: the report strobe lasts a single clock
  a_r7_single_strobe: assert property (@(posedge clk) disable iff (!rst_ni)
    valid_q |=> !valid_q);
  // R7: the count is cleared while the input stays low
  a_r7_idle_clear: assert property (@(posedge clk) disable iff (!rst_ni)
    (!pin_s_q && !pin_d_q) |-> (cnt_q == '0));
  // R8: a saturated count holds until the falling edge
  a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_ni)
    ((cnt_q == CntMax) && !fall) |=> (cnt_q == CntMax));
endmodule

// File: rtl/tdr_timebase.sv
`timescale 1ns/1ps
module tdr_timebase
  import tdr_pkg::*;
#(
  parameter int FINE_W         = 6,
  parameter int COARSE_CODE_W  = 3,
  parameter int COARSE_MAX_LOG = 5,
  parameter int PWM_W          = 8,
  parameter int CAP_W          = 10,
  parameter int RST_STAGES     = 2,
  localparam int PrescW        = FINE_W + COARSE_CODE_W,
  localparam int DataW         = (PrescW > PWM_W) ? PrescW : PWM_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [DataW-1:0] cfg_wdata,
  input  logic             pulse_in,
  output logic             pwm_out,
  output logic             loop_tick,
  output logic             cap_valid,
  output logic [CAP_W-1:0] cap_width
);
  logic     rst_sync_n, fine_tick;
  logic     presc_we, per_we, duty_we;
  tdr_reg_e reg_sel;

  always_comb begin
    reg_sel  = tdr_reg_e'(cfg_addr);
    presc_we = cfg_we && (reg_sel == REG_PRESC);
    per_we   = cfg_we && (reg_sel == REG_PERIOD);
    duty_we  = cfg_we && (reg_sel == REG_DUTY);
  end

  tdr_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_sync_n)
  );

  tdr_prescaler #(
    .FINE_W         (FINE_W),
    .COARSE_CODE_W  (COARSE_CODE_W),
    .COARSE_MAX_LOG (COARSE_MAX_LOG)
  ) u_presc (
    .clk         (clk),
    .rst_ni      (rst_sync_n),
    .we_i        (presc_we),
    .fine_code_i (cfg_wdata[FINE_W-1:0]),
    .crs_code_i  (cfg_wdata[FINE_W +: COARSE_CODE_W]),
    .fine_tick_o (fine_tick),
    .loop_tick_o (loop_tick)
  );

  tdr_pwm #(.PWM_W(PWM_W)) u_pwm (
    .clk         (clk),
    .rst_ni      (rst_sync_n),
    .fine_tick_i (fine_tick),
    .per_we_i    (per_we),
    .duty_we_i   (duty_we),
    .wdata_i     (cfg_wdata[PWM_W-1:0]),
    .pwm_o       (pwm_out)
  );

  tdr_capture #(.CAP_W(CAP_W)) u_cap (
    .clk         (clk),
    .rst_ni      (rst_sync_n),
    .fine_tick_i (fine_tick),
    .pin_i       (pulse_in),
    .valid_o     (cap_valid),
    .width_o     (cap_width)
  );
endmodule

// File: tb/tdr_timebase_test.sv
`timescale 1ns/1ps
module tdr_timebase_test;
  import tdr_pkg::*;

  localparam int CapW   = 10;
  localparam int CapMax = (1 << CapW) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_we = 1'b0;
  logic [1:0]       cfg_addr = 2'd0;
  logic [8:0]       cfg_wdata = 9'd0;
  logic             pulse_in = 1'b0;
  logic             pwm_out, loop_tick, cap_valid;
  logic [CapW-1:0]  cap_width;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tdr_timebase uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .pulse_in  (pulse_in),
    .pwm_out   (pwm_out),
    .loop_tick (loop_tick),
    .cap_valid (cap_valid),
    .cap_width (cap_width)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input tdr_reg_e a, input int d);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_addr  = a;
    cfg_wdata = 9'(d);
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  // loop tick monitor: spacing in clocks between consecutive ticks
  int ct_last = 0, ct_gap = 0, ct_cnt = 0;
  always @(negedge clk) begin
    if (rst_n && loop_tick) begin
      ct_gap  = cyc - ct_last;
      ct_last = cyc;
      ct_cnt++;
    end
  end

  task automatic ct_check(input int exp, input string req);
    int n;
    n = ct_cnt;
    wait (ct_cnt >= n + 3);
    chk(ct_gap == exp, req, ct_gap, exp);
  endtask

  // PWM monitor: length of the last completed high and low runs
  logic pwm_prev = 1'b0;
  int run = 0, hi_run = 0, lo_run = 0, pwm_edges = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (pwm_out == pwm_prev) run++;
      else begin
        if (pwm_prev) hi_run = run;
        else          lo_run = run;
        run = 1;
        pwm_edges++;
        pwm_prev = pwm_out;
      end
    end
  end

  task automatic pwm_check(input int hi, input int lo, input string req);
    int n;
    n = pwm_edges;
    wait (pwm_edges >= n + 6);
    chk(hi_run == hi, {req, " high time"}, hi_run, hi);
    chk(lo_run == lo, {req, " low time"}, lo_run, lo);
  endtask

  task automatic pwm_const(input bit lvl, input int settle, input string req);
    int n;
    repeat (settle) @(negedge clk);
    n = pwm_edges;
    repeat (settle) @(negedge clk);
    chk((pwm_edges == n) && (pwm_out == lvl), req, int'(pwm_out), int'(lvl));
  endtask

  // capture scoreboard
  int q_n[$];
  int q_f[$];

  task automatic drive_pulse(input int n, input int f);
    q_n.push_back(n);
    q_f.push_back(f);
    @(negedge clk);
    pulse_in = 1'b1;
    repeat (n) @(negedge clk);
    pulse_in = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  int m_n, m_f, m_lo, m_hi;
  always @(negedge clk) begin
    if (rst_n && cap_valid) begin
      if (q_n.size() == 0) chk(1'b0, "R7 unexpected capture", int'(cap_width), 0);
      else begin
        m_n  = q_n.pop_front();
        m_f  = q_f.pop_front();
        m_lo = m_n / m_f;
        m_hi = (m_n + m_f - 1) / m_f;
        if (m_lo > CapMax) m_lo = CapMax;
        if (m_hi > CapMax) m_hi = CapMax;
        chk((int'(cap_width) >= m_lo) && (int'(cap_width) <= m_hi),
            (m_n > CapMax) ? "R8 saturated width" : "R7 captured width",
            int'(cap_width), m_lo);
      end
    end
  end

  bit done = 1'b0;
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog expired", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (4) @(negedge clk);
    chk(pwm_out == 1'b0, "R9 pwm low in reset", int'(pwm_out), 0);
    chk(cap_valid == 1'b0, "R9 no capture in reset", int'(cap_valid), 0);
    rst_n = 1'b1;
    n = ct_cnt;
    wait (ct_cnt >= n + 4);
    chk(ct_gap == 1, "R9 loop tick every clock after reset", ct_gap, 1);
    chk(pwm_out == 1'b0, "R9 pwm low after reset", int'(pwm_out), 0);

    // prescale factors: bits [5:0] fine code, [8:6] coarse code
    wr(REG_PRESC, (0 << 6) | 2);  ct_check(3,  "R1 fine code 2");
    wr(REG_PRESC, (0 << 6) | 63); ct_check(64, "R1 fine code 63");
    wr(REG_PRESC, (3 << 6) | 1);  ct_check(16, "R2 coarse code 3");
    wr(REG_PRESC, (5 << 6) | 0);  ct_check(32, "R2 coarse code 5");
    wr(REG_PRESC, (6 << 6) | 0);  ct_check(32, "R3 coarse code 6");
    wr(REG_PRESC, (7 << 6) | 1);  ct_check(64, "R3 coarse code 7");

    // R4: a write in mid period does not shorten it
    wr(REG_PRESC, (3 << 6) | 3);  ct_check(32, "R4 setup period");
    n = ct_cnt;
    wait (ct_cnt >= n + 1);
    wr(REG_PRESC, 0);
    wait (ct_cnt >= n + 2);
    chk(ct_gap == 32, "R4 period kept after write", ct_gap, 32);
    wait (ct_cnt >= n + 3);
    chk(ct_gap == 1, "R4 new codes at next loop tick", ct_gap, 1);

    // PWM
    wr(REG_PERIOD, 5); wr(REG_DUTY, 2);
    pwm_check(2, 3, "R5 period 5 duty 2");
    wr(REG_PERIOD, 4); wr(REG_DUTY, 1);
    pwm_check(1, 3, "R5 one clock high");
    wr(REG_PRESC, 2); ct_check(3, "R1 fine code 2 for pwm");
    pwm_check(3, 9, "R5 fine scaled");
    wr(REG_DUTY, 0);
    pwm_const(1'b0, 40, "R6 zero duty low");
    wr(REG_DUTY, 7);
    pwm_const(1'b1, 40, "R6 duty above period high");

    // capture with fine factor 3, then 1
    drive_pulse(20, 3);
    wr(REG_PRESC, 0); ct_check(1, "R1 fine code 0 for capture");
    drive_pulse(1, 1);
    drive_pulse(7, 1);
    drive_pulse(40, 1);
    drive_pulse(1500, 1);
    repeat (10) @(negedge clk);
    chk(q_n.size() == 0, "R7 every pulse reported", q_n.size(), 0);
    chk(cap_valid == 1'b0, "R7 strobe idle", int'(cap_valid), 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule